// File: doc/BRIEF.md
# Timer Pin GPIO and Edge Capture

This block owns one I/O pin of a general purpose timer. A mode register picks what the pin does. As a general purpose output it can pull the pin low or high. It can also leave the pin floating as an input. An open-drain choice turns a high level into a released pin. In capture mode the pin is never driven. Its level is brought into the clock domain through a chain of flip-flops. A selected transition then sets an event flag, and that flag can raise an interrupt.

Software writes the mode register and reads it back. The status register shows the event flags and the synchronised pin level. Event flags are cleared by writing ones to them. The pin level is visible in status in every mode. This lets software poll an input pin without the capture logic. Counting, compare and waveform generation live elsewhere. In this block those function codes only keep the pin released.

Top module: `tpin_ctrl`

## Requirements
- R1: While `rst_n` is low the mode register and the status register read zero. The pin is released (`pin_oe` = 0, `pin_out` = 0) and `irq` is 0.
- R2: With mode bits 2:0 = 4 (GPIO) and mode bits 5:4 = 10, the pin is driven low: `pin_oe` = 1, `pin_out` = 0.
- R3: With GPIO selected, mode bits 5:4 = 11 and mode bit 9 = 0, the pin is driven high: `pin_oe` = 1, `pin_out` = 1.
- R4: With GPIO selected, mode bits 5:4 = 11 and mode bit 9 = 1 (open drain), the pin is released: `pin_oe` = 0, `pin_out` = 0.
- R5: In every other case the pin is released with `pin_oe` = 0 and `pin_out` = 0. This covers mode bits 5:4 = 0x in GPIO and function codes 0 (off), 1 (capture), 2 (compare) and 3 (PWM). Capture mode never drives the pin, whatever bits 5:4 hold.
- R6: Status bit 8 equals the value `pin_in` had two clock edges earlier, in every mode.
- R7: In capture mode (mode bits 2:0 = 1), mode bits 17:16 choose the edge that sets status bit 0. The codes are 01 rising, 10 falling and 11 either. The flag is set two clock edges after the edge on which the new pin level is first sampled.
- R8: Status bit 0 is never set when mode bits 17:16 = 00 or when the function code is not 1.
- R9: Writing status with a one in bit 0 clears the flag, and a zero there leaves it unchanged. Status bits 3:1 and every bit other than 0 and 8 always read zero.
- R10: When an edge event and a clearing status write fall in the same cycle, the flag ends up set.
- R11: `irq` is high exactly when mode bit 8 is 1 and a status event flag is set.
- R12: A mode write stores the whole written word, and it reads back on `mode_rd` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | REG_W | Mode register write data |
| stat_we | input | 1 | Status register write strobe (write-one-to-clear) |
| stat_wdata | input | REG_W | Status write data; ones in bits 3:0 clear flags |
| mode_rd | output | REG_W | Current mode register contents |
| stat_rd | output | REG_W | Status: flags in bits 3:0, pin level in bit 8 |
| pin_in | input | 1 | Asynchronous level sampled from the pin |
| pin_out | output | 1 | Value driven onto the pin when enabled |
| pin_oe | output | 1 | Pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
First, single pin transitions are run under each edge code. One rising and one falling transition per code show whether the edge selection is decoded the right way round. They also show whether "none" and the non-capture functions suppress the flag. Next, each output field pattern is written in turn. This separates low drive, push-pull high, open-drain release, and the cases where capture or another function must win over the output bits. A clearing write is placed on the exact cycle an edge lands, which sets set-versus-clear priority apart from plain clearing. Last, a long pseudo-random pin sequence with changing modes and sporadic clears is followed by a cycle-by-cycle model. It exposes off-by-one errors in the synchroniser depth or the edge timing.

// File: rtl/tpin_pkg.sv
package tpin_pkg;

  // Mode register field positions (software decodes these)
  localparam int SEL_LSB    = 0;
  localparam int SEL_W      = 3;
  localparam int GOUT_LSB   = 4;
  localparam int IRQEN_BIT  = 8;
  localparam int ODRAIN_BIT = 9;
  localparam int EDGE_LSB   = 16;

  // Status register field positions
  localparam int LEVEL_BIT  = 8;

  typedef enum logic [SEL_W-1:0] {
    FN_OFF     = 3'd0,
    FN_CAPTURE = 3'd1,
    FN_COMPARE = 3'd2,
    FN_PWM     = 3'd3,
    FN_GPIO    = 3'd4
  } fn_sel_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic oe;
    logic val;
  } pin_drv_t;

endpackage

// File: rtl/tpin_sync.sv
module tpin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/tpin_edge.sv
module tpin_edge
  import tpin_pkg::*;
#(
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              level,
  input  logic              arm,
  input  edge_sel_e         edge_sel,
  input  logic              clr_we,
  input  logic [FLAG_W-1:0] clr_mask,
  output logic [FLAG_W-1:0] flags
);

  logic              last_level;
  logic              rise;
  logic              fall;
  logic              hit;
  logic [FLAG_W-1:0] set_vec;
  logic [FLAG_W-1:0] keep_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_level <= 1'b0;
    else        last_level <= level;
  end

  assign rise = level & ~last_level;
  assign fall = ~level & last_level;

  always_comb begin
    hit = 1'b0;
    if (arm) begin
      unique case (edge_sel)
        EDGE_RISE: hit = rise;
        EDGE_FALL: hit = fall;
        EDGE_BOTH: hit = rise | fall;
        default:   hit = 1'b0;
      endcase
    end
  end

  assign set_vec  = FLAG_W'(hit);
  assign keep_vec = clr_we ? ~clr_mask : {FLAG_W{1'b1}};

  // a new event outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= set_vec | (flags & keep_vec);
  end

endmodule

// File: rtl/tpin_drive.sv
module tpin_drive
  import tpin_pkg::*;
(
  input  fn_sel_e   fn_sel,
  input  logic [1:0] gout,
  input  logic      odrain,
  output pin_drv_t  drv
);

  always_comb begin
    drv = '0;
    if (fn_sel == FN_GPIO && gout[1]) begin
      if (gout[0]) begin
        drv.oe  = ~odrain;
        drv.val = ~odrain;
      end else begin
        drv.oe  = 1'b1;
        drv.val = 1'b0;
      end
    end
  end

endmodule

// File: rtl/tpin_ctrl.sv
module tpin_ctrl
  import tpin_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int FLAG_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_we,
  input  logic [REG_W-1:0] mode_wdata,
  input  logic             stat_we,
  input  logic [REG_W-1:0] stat_wdata,
  output logic [REG_W-1:0] mode_rd,
  output logic [REG_W-1:0] stat_rd,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             irq
);

  localparam int SPARE_W = REG_W - FLAG_W;

  logic [REG_W-1:0]  mode_q;
  logic              level;
  logic [FLAG_W-1:0] flags;
  fn_sel_e           fn_sel;
  edge_sel_e         edge_sel;
  pin_drv_t          drv;
  logic              unused_stat_wbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_we) mode_q <= mode_wdata;
  end

  assign fn_sel   = fn_sel_e'(mode_q[SEL_LSB +: SEL_W]);
  assign edge_sel = edge_sel_e'(mode_q[EDGE_LSB +: 2]);

  tpin_sync #(
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (level)
  );

  tpin_edge #(
    .FLAG_W (FLAG_W)
  ) i_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (level),
    .arm      (fn_sel == FN_CAPTURE),
    .edge_sel (edge_sel),
    .clr_we   (stat_we),
    .clr_mask (stat_wdata[FLAG_W-1:0]),
    .flags    (flags)
  );

  tpin_drive i_drive (
    .fn_sel (fn_sel),
    .gout   (mode_q[GOUT_LSB +: 2]),
    .odrain (mode_q[ODRAIN_BIT]),
    .drv    (drv)
  );

  always_comb begin
    stat_rd               = '0;
    stat_rd[FLAG_W-1:0]   = flags;
    stat_rd[LEVEL_BIT]    = level;
  end

  assign mode_rd = mode_q;
  assign pin_oe  = drv.oe;
  assign pin_out = drv.val;
  assign irq     = mode_q[IRQEN_BIT] & (|flags);

  assign unused_stat_wbits = ^{1'b0, stat_wdata[REG_W-1 -: SPARE_W]};

endmodule

// File: rtl/tpin_ctrl_chk.sv
module tpin_ctrl_chk
  import tpin_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int FLAG_W      = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_we,
  input logic [REG_W-1:0] mode_wdata,
  input logic             stat_we,
  input logic [REG_W-1:0] mode_rd,
  input logic [REG_W-1:0] stat_rd,
  input logic             pin_in,
  input logic             pin_out,
  input logic             pin_oe,
  input logic             irq
);

  localparam logic [REG_W-1:0] LIVE_MASK = (REG_W'(1) << LEVEL_BIT) | REG_W'(1);

  logic [SYNC_STAGES-1:0] pin_hist;
  logic                   is_gpio;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_hist <= '0;
    else        pin_hist <= {pin_hist, pin_in};
  end

  assign is_gpio = (mode_rd[SEL_LSB +: SEL_W] == 3'd4);

  // R6: status level follows the pin after the synchroniser delay
  p_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd[LEVEL_BIT] == pin_hist[SYNC_STAGES-1]);

  // R2
  p_drive_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_gpio && mode_rd[GOUT_LSB +: 2] == 2'b10) |-> (pin_oe && !pin_out));

  // R3
  p_drive_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_gpio && mode_rd[GOUT_LSB +: 2] == 2'b11 && !mode_rd[ODRAIN_BIT]) |-> (pin_oe && pin_out));

  // R4
  p_open_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_gpio && mode_rd[GOUT_LSB +: 2] == 2'b11 && mode_rd[ODRAIN_BIT]) |-> (!pin_oe && !pin_out));

  // R5
  p_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_gpio || !mode_rd[GOUT_LSB + 1]) |-> (!pin_oe && !pin_out));

  // R8: a new flag only comes from an armed capture mode
  p_flag_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_rd[0]) |-> ($past(mode_rd[SEL_LSB +: SEL_W]) == 3'd1 &&
                           $past(mode_rd[EDGE_LSB +: 2]) != 2'b00));

  // R9: a flag only drops through a status write
  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd[0] && !stat_we) |=> stat_rd[0]);

  // R9: spare status bits read zero
  p_spare_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd & ~LIVE_MASK) == '0);

  // R11
  p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mode_rd[IRQEN_BIT] && stat_rd[0]));

  // R12
  p_mode_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> (mode_rd == $past(mode_wdata)));

endmodule

bind tpin_ctrl tpin_ctrl_chk #(
  .REG_W       (REG_W),
  .SYNC_STAGES (SYNC_STAGES),
  .FLAG_W      (FLAG_W)
) i_tpin_ctrl_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_we    (mode_we),
  .mode_wdata (mode_wdata),
  .stat_we    (stat_we),
  .mode_rd    (mode_rd),
  .stat_rd    (stat_rd),
  .pin_in     (pin_in),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .irq        (irq)
);

// File: tb/test_tpin_ctrl.sv
module test_tpin_ctrl;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode_we = 1'b0;
  logic [W-1:0] mode_wdata = '0;
  logic         stat_we = 1'b0;
  logic [W-1:0] stat_wdata = '0;
  logic [W-1:0] mode_rd;
  logic [W-1:0] stat_rd;
  logic         pin_in = 1'b0;
  logic         pin_out;
  logic         pin_oe;
  logic         irq;

  always #4 clk = ~clk;  // 125 MHz

  tpin_ctrl i_tpin_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .stat_we    (stat_we),
    .stat_wdata (stat_wdata),
    .mode_rd    (mode_rd),
    .stat_rd    (stat_rd),
    .pin_in     (pin_in),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .irq        (irq)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  bit    finished = 1'b0;
  string cur_tag = "R7";

  // ---------------- behavioural reference model ----------------
  logic [W-1:0] m_mode;
  bit           m_flag;
  bit           pin_seen[$];
  bit           m_now, m_before, m_hit;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode   = '0;
      m_flag   = 1'b0;
      pin_seen = '{1'b0, 1'b0, 1'b0};
    end else begin
      m_now    = pin_seen[pin_seen.size()-2];
      m_before = pin_seen[pin_seen.size()-3];
      m_hit    = (m_mode[2:0] == 3'd1) &&
                 ((m_mode[16] && !m_before && m_now) ||
                  (m_mode[17] && m_before && !m_now));
      m_flag   = m_hit || (m_flag && !(stat_we && stat_wdata[0]));
      if (mode_we) m_mode = mode_wdata;
      pin_seen.push_back(pin_in);
      void'(pin_seen.pop_front());
    end
  end

  function automatic string drive_tag(logic [W-1:0] m);
    if (m[2:0] == 3'd4 && m[5:4] == 2'b10) return "R2";
    if (m[2:0] == 3'd4 && m[5:4] == 2'b11 && !m[9]) return "R3";
    if (m[2:0] == 3'd4 && m[5:4] == 2'b11 && m[9]) return "R4";
    return "R5";
  endfunction

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_model();
    logic [W-1:0] exp_stat;
    bit           e_oe, e_out;
    exp_stat    = '0;
    exp_stat[0] = m_flag;
    exp_stat[8] = pin_seen[pin_seen.size()-2];
    e_oe  = 1'b0;
    e_out = 1'b0;
    if (m_mode[2:0] == 3'd4 && m_mode[5]) begin
      e_oe  = m_mode[4] ? !m_mode[9] : 1'b1;
      e_out = m_mode[4] ? !m_mode[9] : 1'b0;
    end
    chk("R12", "model mode", mode_rd, m_mode);
    chk("R6", "model level", W'(stat_rd[8]), W'(exp_stat[8]));
    chk(cur_tag, "model status", stat_rd, exp_stat);
    chk(drive_tag(m_mode), "model oe/out", W'({pin_oe, pin_out}), W'({e_oe, e_out}));
    chk("R11", "model irq", W'(irq), W'(m_mode[8] && m_flag));
  endtask

  task automatic cyc();
    @(negedge clk);
    if (rst_n) compare_model();
  endtask

  task automatic wait_n(int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  task automatic write_mode(logic [W-1:0] v);
    mode_we = 1'b1; mode_wdata = v;
    cyc();
    mode_we = 1'b0;
  endtask

  task automatic write_stat(logic [W-1:0] v);
    stat_we = 1'b1; stat_wdata = v;
    cyc();
    stat_we = 1'b0;
  endtask

  task automatic drive_case(logic [W-1:0] v, string tag, bit e_oe, bit e_out);
    write_mode(v);
    chk(tag, "pin oe", W'(pin_oe), W'(e_oe));
    chk(tag, "pin out", W'(pin_out), W'(e_out));
  endtask

  // edge test: move pin to v, expect flag state f three edges later
  task automatic edge_case(bit v, bit f, string tag, string what);
    pin_in = v;
    wait_n(3);
    chk(tag, what, W'(stat_rd[0]), W'(f));
    if (stat_rd[0]) write_stat(32'h1);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [15:0] lf;
    logic [W-1:0] pick;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1", "mode in reset", mode_rd, '0);
    chk("R1", "status in reset", stat_rd, '0);
    chk("R1", "oe/out/irq in reset", W'({pin_oe, pin_out, irq}), '0);
    rst_n = 1'b1;
    cyc();

    // R12 readback of the whole word
    write_mode(32'hA5C3_0F12);
    chk("R12", "mode readback", mode_rd, 32'hA5C3_0F12);

    // R2..R5 pin drive
    drive_case(32'h0000_0024, "R2", 1'b1, 1'b0);
    drive_case(32'h0000_0034, "R3", 1'b1, 1'b1);
    drive_case(32'h0000_0234, "R4", 1'b0, 1'b0);
    drive_case(32'h0000_0014, "R5", 1'b0, 1'b0);
    drive_case(32'h0000_0031, "R5", 1'b0, 1'b0);
    drive_case(32'h0000_0032, "R5", 1'b0, 1'b0);
    drive_case(32'h0000_0033, "R5", 1'b0, 1'b0);
    drive_case(32'h0000_0030, "R5", 1'b0, 1'b0);

    // R6 level through the synchroniser, GPIO input mode
    cur_tag = "R6";
    write_mode(32'h0000_0014);
    pin_in = 1'b1;
    cyc();
    chk("R6", "level after one edge", W'(stat_rd[8]), 0);
    cyc();
    chk("R6", "level after two edges", W'(stat_rd[8]), 1);
    pin_in = 1'b0;
    wait_n(2);
    chk("R6", "level returns low", W'(stat_rd[8]), 0);

    // R7 rising only
    cur_tag = "R7";
    write_mode(32'h0001_0001);
    edge_case(1'b1, 1'b1, "R7", "rising select, rise");
    edge_case(1'b0, 1'b0, "R7", "rising select, fall");
    // falling only
    write_mode(32'h0002_0001);
    edge_case(1'b1, 1'b0, "R7", "falling select, rise");
    edge_case(1'b0, 1'b1, "R7", "falling select, fall");
    // either
    write_mode(32'h0003_0001);
    edge_case(1'b1, 1'b1, "R7", "both select, rise");
    edge_case(1'b0, 1'b1, "R7", "both select, fall");

    // R8 no events with select none or outside capture
    cur_tag = "R8";
    write_mode(32'h0000_0001);
    edge_case(1'b1, 1'b0, "R8", "select none, rise");
    edge_case(1'b0, 1'b0, "R8", "select none, fall");
    write_mode(32'h0003_0014);
    edge_case(1'b1, 1'b0, "R8", "gpio mode, rise");
    write_mode(32'h0003_0003);
    edge_case(1'b0, 1'b0, "R8", "pwm code, fall");

    // R9 write-one-to-clear
    cur_tag = "R9";
    write_mode(32'h0003_0001);
    pin_in = 1'b1;
    wait_n(3);
    write_stat(32'hFFFF_FFFE);
    chk("R9", "zero in bit 0 keeps flag", W'(stat_rd[0]), 1);
    write_stat(32'h0000_000F);
    chk("R9", "one in bit 0 clears flag", W'(stat_rd[0]), 0);
    chk("R9", "bits 3:1 read zero", W'(stat_rd[3:1]), 0);

    // R10 set and clear in the same cycle
    cur_tag = "R10";
    pin_in = 1'b0;
    wait_n(2);
    stat_we = 1'b1; stat_wdata = 32'h1;
    cyc();
    stat_we = 1'b0;
    chk("R10", "set wins over clear", W'(stat_rd[0]), 1);
    write_stat(32'h1);
    chk("R10", "later clear works", W'(stat_rd[0]), 0);

    // R11 interrupt gating
    cur_tag = "R11";
    write_mode(32'h0003_0101);
    pin_in = 1'b1;
    wait_n(2);
    chk("R11", "irq low before flag", W'(irq), 0);
    cyc();
    chk("R11", "irq with flag and enable", W'(irq), 1);
    write_mode(32'h0003_0001);
    chk("R11", "irq gated by enable", W'(irq), 0);
    chk("R11", "flag kept while gated", W'(stat_rd[0]), 1);
    write_mode(32'h0003_0101);
    chk("R11", "irq returns", W'(irq), 1);
    write_stat(32'h1);
    chk("R11", "irq drops on clear", W'(irq), 0);

    // pseudo-random pin activity against the model
    cur_tag = "R7";
    lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      case ((i / 64) % 5)
        0: pick = 32'h0001_0101;
        1: pick = 32'h0002_0101;
        2: pick = 32'h0003_0101;
        3: pick = 32'h0003_0134;
        default: pick = 32'h0000_0101;
      endcase
      mode_we    = (i % 64 == 0);
      mode_wdata = pick;
      stat_we    = (lf[6:4] == 3'd0);
      stat_wdata = lf[9] ? 32'hF : 32'hE;
      pin_in     = lf[0] ^ lf[3];
      cyc();
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    end
    mode_we = 1'b0;
    stat_we = 1'b0;
    wait_n(3);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule